// File: doc/BRIEF.md
# Ingress Bus Address Window Matcher

This block classifies every incoming bus request by its address. It holds a small set of programmable windows. Each window is tied to one MAC port and covers a 4 kB-aligned span of bus addresses. Each window also names a target virtual base, an address-space identifier (ASID) and an ordering mode. When a request falls inside an enabled window on its own port, the block reports the winning window, the offset of the request into that window, the translated virtual address, and the window's ASID and ordering mode. A request that falls in no window is flagged as unmapped.

The windows are written through a one-cycle configuration port. Every write is validated before it takes effect. A write that fails validation leaves the window untouched and returns an error code, so the request path only ever sees ranges that are aligned and in bounds. Packet parsing, physical translation and the memory system are not part of this block.

Top module: `bus_window_matcher`

## Requirements
- R1: While reset is asserted and after its release, every window is empty, and `cfg_done`, `rsp_hit` and `rsp_miss` are low. A request made before any configuration write reports a miss.
- R2: A configuration write asserts `cfg_done` for exactly one cycle, in the cycle after `cfg_valid`. When the write is valid, `cfg_status` returns 0 and the window takes the written settings. When no write is made, `cfg_done` is low and `cfg_status` is 0.
- R3: A write whose `cfg_win` is NUM_WIN or higher returns status 1.
- R4: A write with a valid index whose ASID is NUM_ASID or higher returns status 2.
- R5: A write returns status 3 in any of these cases: a bus base, length or target base with any of bits 11:0 set; a base plus length above 2^ADDR_W; or a target base plus length above 2^VA_W. A window that ends exactly at the top of the space is legal.
- R6: An ordering code of 3 returns status 4. The legal codes are 0 (unordered), 1 (strict) and 2 (follow the packet's relaxed-ordering attribute). When a write has several faults, the lowest status code among them is returned. A rejected write changes no window.
- R7: A request matches a window when `req_mac` equals the window's MAC and base <= addr < base + length. `rsp_hit` and `rsp_win` appear in the cycle after `req_valid`, and requests may be issued back to back.
- R8: When several windows match one request, the lowest window index is reported.
- R9: On a hit, `rsp_offset` is addr minus the window base, and `rsp_va` is the target base plus that offset, so bits 11:0 of the address pass through unchanged. `rsp_asid` and `rsp_order` carry the window's settings.
- R10: For a request that matches nothing, `rsp_miss` is set and `rsp_hit` is clear. All other response fields are zero on a miss and in any cycle without a request.
- R11: A valid write with length 0 is accepted with status 0 and disables the window, so that window never matches.
- R12: A request issued in the same cycle as a configuration write is matched against the windows as they stood before that write. The new settings apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_win | input | CIDX_W | Window index to write; it is one bit wider than needed, so out-of-range indices can be expressed |
| cfg_bus_base | input | ADDR_W | Bus address where the window starts |
| cfg_len | input | ADDR_W | Window length in bytes; 0 disables the window |
| cfg_tgt_base | input | VA_W | Target virtual base address |
| cfg_asid | input | ASID_W | Address-space identifier |
| cfg_mac | input | MAC_W | MAC port that owns the window |
| cfg_order | input | 2 | Ordering mode code |
| cfg_done | output | 1 | Write completed (one cycle after `cfg_valid`) |
| cfg_status | output | 3 | 0 ok, 1 bad window, 2 bad ASID, 3 bad range, 4 bad ordering |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Request bus address |
| req_mac | input | MAC_W | MAC port the request came in on |
| rsp_hit | output | 1 | Request matched a window |
| rsp_miss | output | 1 | Request matched no window |
| rsp_win | output | IDX_W | Index of the matching window |
| rsp_offset | output | ADDR_W | Byte offset into the window |
| rsp_va | output | VA_W | Translated virtual address |
| rsp_asid | output | ASID_W | ASID of the matching window |
| rsp_order | output | 2 | Ordering mode of the matching window |

## Verification
The bench builds the block with its defaults: eight windows, a 40-bit bus, a 42-bit virtual space, a 4-bit ASID field with twelve ASIDs allocated, and four MAC ports. With these values, the indices 8 to 15 and the ASIDs 12 to 15 can be written on the configuration port, so both rejection paths can be driven. The top of the bus space and the top of the virtual space are within reach, which exercises both the overflow check and the legal window that ends exactly at the top. A behavioural model then runs a mixed sweep of overlapping windows on several ports, writes with faults, zero-length writes and same-cycle write-and-request pairs, and compares every response field on every clock.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  localparam int PAGE_SHIFT = 12;

  typedef enum logic [1:0] {
    ORD_UNORDERED = 2'd0,
    ORD_STRICT    = 2'd1,
    ORD_OBEY_PKT  = 2'd2,
    ORD_RESERVED  = 2'd3
  } order_e;

  typedef enum logic [2:0] {
    ST_OK         = 3'd0,
    ST_BAD_WINDOW = 3'd1,
    ST_BAD_ASID   = 3'd2,
    ST_BAD_RANGE  = 3'd3,
    ST_BAD_ORDER  = 3'd4
  } cfg_status_e;

endpackage

// File: rtl/bwm_cfg_check.sv
module bwm_cfg_check #(
  parameter int NUM_WIN  = 8,
  parameter int NUM_ASID = 12,
  parameter int ADDR_W   = 40,
  parameter int VA_W     = 42,
  parameter int ASID_W   = 4,
  parameter int CIDX_W   = 4
) (
  input  logic [CIDX_W-1:0]  win_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [ADDR_W-1:0]  len_i,
  input  logic [VA_W-1:0]    tgt_i,
  input  logic [ASID_W-1:0]  asid_i,
  input  logic [1:0]         order_i,
  output bwm_pkg::cfg_status_e status_o
);
  import bwm_pkg::*;

  localparam int SUM_W = ((VA_W > ADDR_W) ? VA_W : ADDR_W) + 1;
  localparam logic [SUM_W-1:0] ONE_S  = {{(SUM_W-1){1'b0}}, 1'b1};
  localparam logic [SUM_W-1:0] BUS_TOP = ONE_S << ADDR_W;
  localparam logic [SUM_W-1:0] VA_TOP  = ONE_S << VA_W;

  logic [SUM_W-1:0] bus_end;
  logic [SUM_W-1:0] va_end;
  logic             win_bad;
  logic             asid_bad;
  logic             misaligned;
  logic             range_bad;
  logic             order_bad;

  always_comb begin
    bus_end    = SUM_W'(base_i) + SUM_W'(len_i);
    va_end     = SUM_W'(tgt_i) + SUM_W'(len_i);
    win_bad    = int'(win_i) >= NUM_WIN;
    asid_bad   = int'(asid_i) >= NUM_ASID;
    misaligned = (|base_i[PAGE_SHIFT-1:0]) || (|len_i[PAGE_SHIFT-1:0]) ||
                 (|tgt_i[PAGE_SHIFT-1:0]);
    range_bad  = misaligned || (bus_end > BUS_TOP) || (va_end > VA_TOP);
    order_bad  = order_i == ORD_RESERVED;
  end

  // Fault priority: index, then ASID, then range, then ordering code.
  always_comb begin
    if (win_bad)        status_o = ST_BAD_WINDOW;
    else if (asid_bad)  status_o = ST_BAD_ASID;
    else if (range_bad) status_o = ST_BAD_RANGE;
    else if (order_bad) status_o = ST_BAD_ORDER;
    else                status_o = ST_OK;
  end

endmodule

// File: rtl/bwm_window_regs.sv
module bwm_window_regs #(
  parameter int NUM_WIN = 8,
  parameter int ADDR_W  = 40,
  parameter int VA_W    = 42,
  parameter int ASID_W  = 4,
  parameter int MAC_W   = 2,
  localparam int IDX_W  = $clog2(NUM_WIN),
  localparam int BP_W   = ADDR_W - bwm_pkg::PAGE_SHIFT,
  localparam int TP_W   = VA_W - bwm_pkg::PAGE_SHIFT
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [BP_W-1:0]                 wr_base_pg,
  input  logic [BP_W-1:0]                 wr_len_pg,
  input  logic [TP_W-1:0]                 wr_tgt_pg,
  input  logic [ASID_W-1:0]               wr_asid,
  input  logic [MAC_W-1:0]                wr_mac,
  input  logic [1:0]                      wr_order,
  output logic [NUM_WIN-1:0][BP_W-1:0]    base_pg_o,
  output logic [NUM_WIN-1:0][BP_W-1:0]    len_pg_o,
  output logic [NUM_WIN-1:0][TP_W-1:0]    tgt_pg_o,
  output logic [NUM_WIN-1:0][ASID_W-1:0]  asid_o,
  output logic [NUM_WIN-1:0][MAC_W-1:0]   mac_o,
  output logic [NUM_WIN-1:0][1:0]         order_o
);

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic load;
    assign load = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_pg_o[g] <= '0;
        len_pg_o[g]  <= '0;
        tgt_pg_o[g]  <= '0;
        asid_o[g]    <= '0;
        mac_o[g]     <= '0;
        order_o[g]   <= '0;
      end else if (load) begin
        base_pg_o[g] <= wr_base_pg;
        len_pg_o[g]  <= wr_len_pg;
        tgt_pg_o[g]  <= wr_tgt_pg;
        asid_o[g]    <= wr_asid;
        mac_o[g]     <= wr_mac;
        order_o[g]   <= wr_order;
      end
    end
  end

endmodule

// File: rtl/bwm_window_cmp.sv
module bwm_window_cmp #(
  parameter int ADDR_W = 40,
  parameter int MAC_W  = 2,
  localparam int BP_W  = ADDR_W - bwm_pkg::PAGE_SHIFT
) (
  input  logic [BP_W-1:0]  req_pg_i,
  input  logic [MAC_W-1:0] req_mac_i,
  input  logic [BP_W-1:0]  base_pg_i,
  input  logic [BP_W-1:0]  len_pg_i,
  input  logic [MAC_W-1:0] mac_i,
  output logic             hit_o
);
  logic [BP_W-1:0] rel_pg;

  always_comb begin
    rel_pg = req_pg_i - base_pg_i;
    hit_o  = (len_pg_i != '0) && (req_mac_i == mac_i) &&
             (req_pg_i >= base_pg_i) && (rel_pg < len_pg_i);
  end

endmodule

// File: rtl/bwm_resp_pick.sv
module bwm_resp_pick #(
  parameter int NUM_WIN = 8,
  parameter int ADDR_W  = 40,
  parameter int VA_W    = 42,
  parameter int ASID_W  = 4,
  localparam int IDX_W  = $clog2(NUM_WIN),
  localparam int BP_W   = ADDR_W - bwm_pkg::PAGE_SHIFT,
  localparam int TP_W   = VA_W - bwm_pkg::PAGE_SHIFT
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid_i,
  input  logic [ADDR_W-1:0]              req_addr_i,
  input  logic [NUM_WIN-1:0]             hit_vec_i,
  input  logic [NUM_WIN-1:0][BP_W-1:0]   base_pg_i,
  input  logic [NUM_WIN-1:0][TP_W-1:0]   tgt_pg_i,
  input  logic [NUM_WIN-1:0][ASID_W-1:0] asid_i,
  input  logic [NUM_WIN-1:0][1:0]        order_i,
  output logic                           hit_o,
  output logic                           miss_o,
  output logic [IDX_W-1:0]               win_o,
  output logic [ADDR_W-1:0]              off_o,
  output logic [VA_W-1:0]                va_o,
  output logic [ASID_W-1:0]              asid_o,
  output logic [1:0]                     order_o
);
  localparam logic [bwm_pkg::PAGE_SHIFT-1:0] PG_ZERO = '0;

  logic [IDX_W-1:0]  sel;
  logic              any_hit;
  logic              hit_n;
  logic              miss_n;
  logic [IDX_W-1:0]  win_n;
  logic [ADDR_W-1:0] off_n;
  logic [VA_W-1:0]   va_n;
  logic [ASID_W-1:0] asid_n;
  logic [1:0]        order_n;

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    sel = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec_i[i]) sel = IDX_W'(i);
    end
    any_hit = |hit_vec_i;
  end

  always_comb begin
    hit_n   = req_valid_i && any_hit;
    miss_n  = req_valid_i && !any_hit;
    win_n   = '0;
    off_n   = '0;
    va_n    = '0;
    asid_n  = '0;
    order_n = '0;
    if (hit_n) begin
      win_n   = sel;
      off_n   = req_addr_i - {base_pg_i[sel], PG_ZERO};
      va_n    = {tgt_pg_i[sel], PG_ZERO} + VA_W'(off_n);
      asid_n  = asid_i[sel];
      order_n = order_i[sel];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_o   <= 1'b0;
      miss_o  <= 1'b0;
      win_o   <= '0;
      off_o   <= '0;
      va_o    <= '0;
      asid_o  <= '0;
      order_o <= '0;
    end else begin
      hit_o   <= hit_n;
      miss_o  <= miss_n;
      win_o   <= win_n;
      off_o   <= off_n;
      va_o    <= va_n;
      asid_o  <= asid_n;
      order_o <= order_n;
    end
  end

endmodule

// File: rtl/bus_window_matcher.sv
module bus_window_matcher #(
  parameter int NUM_WIN  = 8,
  parameter int NUM_ASID = 12,
  parameter int NUM_MAC  = 4,
  parameter int ADDR_W   = 40,
  parameter int VA_W     = 42,
  parameter int ASID_W   = 4,
  localparam int IDX_W   = $clog2(NUM_WIN),
  localparam int CIDX_W  = IDX_W + 1,
  localparam int MAC_W   = $clog2(NUM_MAC),
  localparam int BP_W    = ADDR_W - bwm_pkg::PAGE_SHIFT,
  localparam int TP_W    = VA_W - bwm_pkg::PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [CIDX_W-1:0] cfg_win,
  input  logic [ADDR_W-1:0] cfg_bus_base,
  input  logic [ADDR_W-1:0] cfg_len,
  input  logic [VA_W-1:0]   cfg_tgt_base,
  input  logic [ASID_W-1:0] cfg_asid,
  input  logic [MAC_W-1:0]  cfg_mac,
  input  logic [1:0]        cfg_order,
  output logic              cfg_done,
  output logic [2:0]        cfg_status,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [MAC_W-1:0]  req_mac,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [IDX_W-1:0]  rsp_win,
  output logic [ADDR_W-1:0] rsp_offset,
  output logic [VA_W-1:0]   rsp_va,
  output logic [ASID_W-1:0] rsp_asid,
  output logic [1:0]        rsp_order
);
  import bwm_pkg::*;

  localparam int PS = PAGE_SHIFT;

  cfg_status_e                     chk_status;
  logic                            wr_en;
  logic                            done_n;
  logic [2:0]                      status_n;
  logic [NUM_WIN-1:0][BP_W-1:0]    w_base;
  logic [NUM_WIN-1:0][BP_W-1:0]    w_len;
  logic [NUM_WIN-1:0][TP_W-1:0]    w_tgt;
  logic [NUM_WIN-1:0][ASID_W-1:0]  w_asid;
  logic [NUM_WIN-1:0][MAC_W-1:0]   w_mac;
  logic [NUM_WIN-1:0][1:0]         w_order;
  logic [NUM_WIN-1:0]              hit_vec;

  bwm_cfg_check #(
    .NUM_WIN  (NUM_WIN),
    .NUM_ASID (NUM_ASID),
    .ADDR_W   (ADDR_W),
    .VA_W     (VA_W),
    .ASID_W   (ASID_W),
    .CIDX_W   (CIDX_W)
  ) u_check (
    .win_i    (cfg_win),
    .base_i   (cfg_bus_base),
    .len_i    (cfg_len),
    .tgt_i    (cfg_tgt_base),
    .asid_i   (cfg_asid),
    .order_i  (cfg_order),
    .status_o (chk_status)
  );

  always_comb begin
    wr_en    = cfg_valid && (chk_status == ST_OK);
    done_n   = cfg_valid;
    status_n = cfg_valid ? 3'(chk_status) : 3'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_done   <= 1'b0;
      cfg_status <= 3'd0;
    end else begin
      cfg_done   <= done_n;
      cfg_status <= status_n;
    end
  end

  bwm_window_regs #(
    .NUM_WIN (NUM_WIN),
    .ADDR_W  (ADDR_W),
    .VA_W    (VA_W),
    .ASID_W  (ASID_W),
    .MAC_W   (MAC_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (cfg_win[IDX_W-1:0]),
    .wr_base_pg (cfg_bus_base[ADDR_W-1:PS]),
    .wr_len_pg  (cfg_len[ADDR_W-1:PS]),
    .wr_tgt_pg  (cfg_tgt_base[VA_W-1:PS]),
    .wr_asid    (cfg_asid),
    .wr_mac     (cfg_mac),
    .wr_order   (cfg_order),
    .base_pg_o  (w_base),
    .len_pg_o   (w_len),
    .tgt_pg_o   (w_tgt),
    .asid_o     (w_asid),
    .mac_o      (w_mac),
    .order_o    (w_order)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    bwm_window_cmp #(
      .ADDR_W (ADDR_W),
      .MAC_W  (MAC_W)
    ) u_cmp (
      .req_pg_i  (req_addr[ADDR_W-1:PS]),
      .req_mac_i (req_mac),
      .base_pg_i (w_base[g]),
      .len_pg_i  (w_len[g]),
      .mac_i     (w_mac[g]),
      .hit_o     (hit_vec[g])
    );
  end

  bwm_resp_pick #(
    .NUM_WIN (NUM_WIN),
    .ADDR_W  (ADDR_W),
    .VA_W    (VA_W),
    .ASID_W  (ASID_W)
  ) u_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid),
    .req_addr_i  (req_addr),
    .hit_vec_i   (hit_vec),
    .base_pg_i   (w_base),
    .tgt_pg_i    (w_tgt),
    .asid_i      (w_asid),
    .order_i     (w_order),
    .hit_o       (rsp_hit),
    .miss_o      (rsp_miss),
    .win_o       (rsp_win),
    .off_o       (rsp_offset),
    .va_o        (rsp_va),
    .asid_o      (rsp_asid),
    .order_o     (rsp_order)
  );

endmodule

// File: rtl/bwm_checker.sv
module bwm_checker #(
  parameter int NUM_WIN  = 8,
  parameter int NUM_ASID = 12,
  parameter int ADDR_W   = 40,
  parameter int VA_W     = 42,
  parameter int ASID_W   = 4,
  parameter int CIDX_W   = 4,
  parameter int IDX_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_valid,
  input logic [CIDX_W-1:0] cfg_win,
  input logic [ASID_W-1:0] cfg_asid,
  input logic              cfg_done,
  input logic [2:0]        cfg_status,
  input logic              req_valid,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic [IDX_W-1:0]  rsp_win,
  input logic [ADDR_W-1:0] rsp_offset,
  input logic [VA_W-1:0]   rsp_va,
  input logic [ASID_W-1:0] rsp_asid,
  input logic [1:0]        rsp_order
);

  p_done_follows_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> cfg_done);

  p_quiet_cfg_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> (!cfg_done && cfg_status == 3'd0));

  p_bad_index_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && int'(cfg_win) >= NUM_WIN) |=> cfg_status == 3'd1);

  p_bad_asid_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && int'(cfg_win) < NUM_WIN && int'(cfg_asid) >= NUM_ASID)
      |=> cfg_status == 3'd2);

  p_one_answer_per_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_hit != rsp_miss));

  p_silent_without_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_hit && !rsp_miss));

  p_miss_fields_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_win == '0 && rsp_offset == '0 && rsp_va == '0 &&
                  rsp_asid == '0 && rsp_order == 2'd0));

  p_page_bits_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_va[11:0] == rsp_offset[11:0]);

  p_legal_order_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_order != 2'd3);

endmodule

bind bus_window_matcher bwm_checker #(
  .NUM_WIN  (NUM_WIN),
  .NUM_ASID (NUM_ASID),
  .ADDR_W   (ADDR_W),
  .VA_W     (VA_W),
  .ASID_W   (ASID_W),
  .CIDX_W   (CIDX_W),
  .IDX_W    (IDX_W)
) u_bwm_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_valid  (cfg_valid),
  .cfg_win    (cfg_win),
  .cfg_asid   (cfg_asid),
  .cfg_done   (cfg_done),
  .cfg_status (cfg_status),
  .req_valid  (req_valid),
  .rsp_hit    (rsp_hit),
  .rsp_miss   (rsp_miss),
  .rsp_win    (rsp_win),
  .rsp_offset (rsp_offset),
  .rsp_va     (rsp_va),
  .rsp_asid   (rsp_asid),
  .rsp_order  (rsp_order)
);

// File: tb/bus_window_matcher_tb_top.sv
module bus_window_matcher_tb_top;

  localparam int NW = 8;
  localparam int NA = 12;
  localparam longint unsigned BUS_SPAN = 64'h100_0000_0000;
  localparam longint unsigned VA_SPAN  = 64'h400_0000_0000;

  logic        clk;
  logic        rst_n;
  logic        cfg_valid;
  logic [3:0]  cfg_win;
  logic [39:0] cfg_bus_base;
  logic [39:0] cfg_len;
  logic [41:0] cfg_tgt_base;
  logic [3:0]  cfg_asid;
  logic [1:0]  cfg_mac;
  logic [1:0]  cfg_order;
  logic        cfg_done;
  logic [2:0]  cfg_status;
  logic        req_valid;
  logic [39:0] req_addr;
  logic [1:0]  req_mac;
  logic        rsp_hit;
  logic        rsp_miss;
  logic [2:0]  rsp_win;
  logic [39:0] rsp_offset;
  logic [41:0] rsp_va;
  logic [3:0]  rsp_asid;
  logic [1:0]  rsp_order;

  bus_window_matcher dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_valid    (cfg_valid),
    .cfg_win      (cfg_win),
    .cfg_bus_base (cfg_bus_base),
    .cfg_len      (cfg_len),
    .cfg_tgt_base (cfg_tgt_base),
    .cfg_asid     (cfg_asid),
    .cfg_mac      (cfg_mac),
    .cfg_order    (cfg_order),
    .cfg_done     (cfg_done),
    .cfg_status   (cfg_status),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_mac      (req_mac),
    .rsp_hit      (rsp_hit),
    .rsp_miss     (rsp_miss),
    .rsp_win      (rsp_win),
    .rsp_offset   (rsp_offset),
    .rsp_va       (rsp_va),
    .rsp_asid     (rsp_asid),
    .rsp_order    (rsp_order)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  string phase    = "R1";
  bit    finished = 0;

  longint unsigned m_base [NW];
  longint unsigned m_len  [NW];
  longint unsigned m_tgt  [NW];
  int              m_asid [NW];
  int              m_mac  [NW];
  int              m_ord  [NW];

  longint unsigned e_done, e_status, e_hit, e_miss, e_win, e_off, e_va, e_asid, e_ord;

  function automatic int model_status(int idx, longint unsigned b, longint unsigned l,
                                      longint unsigned t, int a, int o);
    if (idx >= NW) return 1;
    if (a >= NA) return 2;
    if ((b & 64'hFFF) != 0 || (l & 64'hFFF) != 0 || (t & 64'hFFF) != 0) return 3;
    if (b + l > BUS_SPAN || t + l > VA_SPAN) return 3;
    if (o == 3) return 4;
    return 0;
  endfunction

  task automatic check(string what, longint unsigned act, longint unsigned exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  // Reference model: evaluates the inputs present at each edge, then compares.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) begin
        m_base[i] = 0; m_len[i] = 0; m_tgt[i] = 0;
        m_asid[i] = 0; m_mac[i] = 0; m_ord[i] = 0;
      end
      e_done = 0; e_status = 0; e_hit = 0; e_miss = 0;
      e_win = 0; e_off = 0; e_va = 0; e_asid = 0; e_ord = 0;
    end else begin
      int st;
      bit found;
      st = cfg_valid ? model_status(int'(cfg_win), cfg_bus_base, cfg_len,
                                    cfg_tgt_base, int'(cfg_asid), int'(cfg_order)) : 0;
      e_done = cfg_valid;
      e_status = st;
      found = 0;
      e_win = 0; e_off = 0; e_va = 0; e_asid = 0; e_ord = 0;
      if (req_valid) begin
        for (int i = 0; i < NW; i++) begin
          if (!found && m_len[i] != 0 && m_mac[i] == int'(req_mac) &&
              req_addr >= m_base[i] && req_addr < m_base[i] + m_len[i]) begin
            found  = 1;
            e_win  = i;
            e_off  = req_addr - m_base[i];
            e_va   = m_tgt[i] + e_off;
            e_asid = m_asid[i];
            e_ord  = m_ord[i];
          end
        end
      end
      e_hit  = req_valid && found;
      e_miss = req_valid && !found;
      // R12: the write lands only after the request has been looked up.
      if (cfg_valid && st == 0) begin
        m_base[cfg_win] = cfg_bus_base;
        m_len[cfg_win]  = cfg_len;
        m_tgt[cfg_win]  = cfg_tgt_base;
        m_asid[cfg_win] = cfg_asid;
        m_mac[cfg_win]  = cfg_mac;
        m_ord[cfg_win]  = cfg_order;
      end
    end
    #1;
    check("cfg_done",   cfg_done,   e_done);
    check("cfg_status", cfg_status, e_status);
    check("rsp_hit",    rsp_hit,    e_hit);
    check("rsp_miss",   rsp_miss,   e_miss);
    check("rsp_win",    rsp_win,    e_win);
    check("rsp_offset", rsp_offset, e_off);
    check("rsp_va",     rsp_va,     e_va);
    check("rsp_asid",   rsp_asid,   e_asid);
    check("rsp_order",  rsp_order,  e_ord);
  end

  task automatic idle();
    @(negedge clk);
    cfg_valid = 0;
    req_valid = 0;
  endtask

  task automatic put_cfg(int idx, longint unsigned b, longint unsigned l,
                         longint unsigned t, int a, int m, int o);
    cfg_valid    = 1;
    cfg_win      = 4'(idx);
    cfg_bus_base = 40'(b);
    cfg_len      = 40'(l);
    cfg_tgt_base = 42'(t);
    cfg_asid     = 4'(a);
    cfg_mac      = 2'(m);
    cfg_order    = 2'(o);
  endtask

  task automatic wr(int idx, longint unsigned b, longint unsigned l,
                    longint unsigned t, int a, int m, int o);
    @(negedge clk);
    put_cfg(idx, b, l, t, a, m, o);
    req_valid = 0;
  endtask

  task automatic rq(longint unsigned addr, int m);
    @(negedge clk);
    cfg_valid = 0;
    req_valid = 1;
    req_addr  = 40'(addr);
    req_mac   = 2'(m);
  endtask

  task automatic both(int idx, longint unsigned b, longint unsigned l,
                      longint unsigned t, int a, int m, int o,
                      longint unsigned addr, int rm);
    @(negedge clk);
    put_cfg(idx, b, l, t, a, m, o);
    req_valid = 1;
    req_addr  = 40'(addr);
    req_mac   = 2'(rm);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog: actual still running, expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    cfg_valid = 0; cfg_win = 0; cfg_bus_base = 0; cfg_len = 0; cfg_tgt_base = 0;
    cfg_asid = 0; cfg_mac = 0; cfg_order = 0;
    req_valid = 0; req_addr = 0; req_mac = 0;

    phase = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    rq(40'h10000, 1);
    rq(40'h0, 0);
    idle();

    phase = "R2";
    wr(0, 40'h10000, 40'h3000, 42'h2_0000_0000, 3, 1, 2);
    idle();

    phase = "R7";
    rq(40'h10000, 1);
    rq(40'h12FFF, 1);
    rq(40'h13000, 1);
    rq(40'h0FFFF, 1);
    rq(40'h10000, 0);
    idle();

    phase = "R9";
    rq(40'h11234, 1);
    rq(40'h12ABC, 1);
    idle();

    phase = "R8";
    wr(1, 40'h11000, 40'h1000, 42'h5_0000_0000, 7, 1, 1);
    wr(3, 40'h40000, 40'h2000, 42'h6_0000_0000, 5, 2, 0);
    wr(2, 40'h41000, 40'h1000, 42'h7_0000_0000, 9, 2, 1);
    rq(40'h11800, 1);
    rq(40'h41800, 2);
    rq(40'h40800, 2);
    rq(40'h41800, 3);
    idle();

    phase = "R3";
    wr(8, 40'h10000, 40'h1000, 42'h1000, 1, 1, 0);
    wr(15, 40'h10000, 40'h1000, 42'h1000, 1, 1, 0);
    wr(9, 40'h10001, 40'h1000, 42'h1000, 13, 1, 3);
    rq(40'h10000, 1);
    idle();

    phase = "R4";
    wr(0, 40'h90000, 40'h1000, 42'h1000, 12, 0, 0);
    wr(0, 40'h90000, 40'h1000, 42'h1000, 15, 0, 0);
    wr(0, 40'h90001, 40'h1000, 42'h1000, 14, 0, 3);
    rq(40'h90000, 0);
    rq(40'h10000, 1);
    idle();

    phase = "R5";
    wr(5, 40'h10800, 40'h1000, 42'h1000, 1, 0, 0);
    wr(5, 40'h20000, 40'h1800, 42'h1000, 1, 0, 0);
    wr(5, 40'h20000, 40'h1000, 42'h1100, 1, 0, 0);
    wr(5, 40'hFF_FFFF_F000, 40'h2000, 42'h1000, 1, 0, 0);
    wr(5, 40'h20000, 40'h2000, 42'h3FF_FFFF_F000, 1, 0, 0);
    wr(5, 40'h20001, 40'h1000, 42'h1000, 1, 0, 3);
    rq(40'hFF_FFFF_F800, 0);
    wr(5, 40'hFF_FFFF_F000, 40'h1000, 42'h3FF_FFFF_F000, 2, 0, 1);
    rq(40'hFF_FFFF_FFFF, 0);
    rq(40'hFF_FFFF_F000, 0);
    idle();

    phase = "R6";
    wr(6, 40'h30000, 40'h1000, 42'h8000, 4, 3, 3);
    wr(6, 40'h30000, 40'h1000, 42'h8000, 13, 3, 3);
    rq(40'h30000, 3);
    wr(6, 40'h30000, 40'h1000, 42'h8000, 4, 3, 0);
    rq(40'h30010, 3);
    idle();

    phase = "R11";
    wr(0, 40'h10000, 40'h0, 42'h0, 0, 1, 0);
    rq(40'h10000, 1);
    rq(40'h11000, 1);
    rq(40'h12000, 1);
    idle();

    phase = "R12";
    both(4, 40'h80000, 40'h1000, 42'h9_0000_0000, 11, 3, 2, 40'h80040, 3);
    rq(40'h80040, 3);
    both(4, 40'h80000, 40'h0, 42'h0, 0, 3, 0, 40'h80040, 3);
    rq(40'h80040, 3);
    idle();

    phase = "R10";
    repeat (3) idle();
    rq(40'h7_0000_0000, 2);
    idle();

    phase = "R7";
    for (int n = 0; n < 600; n++) begin
      int kind;
      kind = int'($urandom % 4);
      if (kind == 0) begin
        longint unsigned b, l, t;
        b = longint'($urandom % 32) << 12;
        l = longint'($urandom % 4) << 12;
        t = longint'($urandom % 1024) << 12;
        if (($urandom % 8) == 0) b = b | 64'h400;
        wr(int'($urandom % 10), b, l, t, int'($urandom % 16),
           int'($urandom % 4), int'($urandom % 4));
      end else if (kind == 1) begin
        idle();
      end else begin
        rq(longint'($urandom % (36 * 4096)), int'($urandom % 4));
      end
    end
    idle();
    idle();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule